// File: doc/BRIEF.md
# SIMD Condition Flag Update Unit

This block keeps the per-lane zero, negative and carry flags of a 16-lane SIMD core that issues one ADD-ALU operation and one MUL-ALU operation in each instruction. In every instruction cycle it evaluates each ALU's condition code against the flags held for each lane. It produces the per-lane register write enables for both ALUs. When a flag update is requested, it chooses which ALU's results feed the flag registers.

Branches also pass through the block. A branch writes its link value, and may set flags, only when it is taken. The block forms the branch target from SIMD lane 15 of a register operand plus an offset. A branch also requests a flag update when the low bit of its register-A read address is one, because the set-flags bit and that address bit share one instruction position. Instruction decode and the arithmetic itself happen elsewhere: the block receives decoded controls, 32-bit results and carry-outs.

Top module: `simd_flag_unit`

## Requirements
- R1: Condition codes use the encoding 0 never, 1 always, 2 zero set, 3 zero clear, 4 negative set, 5 negative clear, 6 carry set, 7 carry clear. They are evaluated in each lane against that lane's currently held flags. `add_wen`/`mul_wen` reflect the result in the same cycle and are zero when `instr_valid` is low.
- R2: A flag update changes only lanes whose selected ALU write enable is high. The new flags are visible from the cycle after the instruction.
- R3: Updated flags are zero = result bits all zero, negative = result bit 31, carry = that lane's ALU carry-out.
- R4: When `add_nop` is low, flags come from the ADD ALU. MUL results, carries and MUL write enables then have no effect on the flags.
- R5: When `add_nop` is high, `add_wen` is all zero and flags come from the MUL ALU, gated only by the MUL condition. The ADD condition code, including never, does not suppress the update.
- R6: Flags hold when the instruction is idle or requests no flag update.
- R7: A branch requests a flag update when `set_flags` is high or `raddr_a_lsb` is high.
- R8: A taken branch raises `link_wen`. If it requests flags, every lane takes zero = (`link_val` == 0), negative = `link_val` bit 31, carry = 0. A branch that is not taken writes neither the link nor the flags.
- R9: During a branch, `add_wen` and `mul_wen` are all zero.
- R10: `br_target` equals `br_offset` plus, when `br_use_reg` is high, SIMD lane 15 of `br_reg_vec`, modulo 2^32.
- R11: Reset clears all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | An instruction issues this cycle |
| is_branch | input | 1 | The instruction is a branch |
| set_flags | input | 1 | Explicit set-flags request |
| raddr_a_lsb | input | 1 | Low bit of the register-A read address (shared bit on branches) |
| add_nop | input | 1 | The ADD ALU executes a nop |
| cond_add | input | 3 | ADD ALU condition code |
| cond_mul | input | 3 | MUL ALU condition code |
| add_res | input | 512 | ADD results, lane i at bits 32i+31..32i |
| add_cy | input | 16 | ADD carry-out per lane |
| mul_res | input | 512 | MUL results, same packing |
| mul_cy | input | 16 | MUL carry-out per lane |
| br_taken | input | 1 | The branch condition holds |
| br_use_reg | input | 1 | The branch adds a register operand to the target |
| br_reg_vec | input | 512 | Register operand vector for the branch |
| br_offset | input | 32 | Branch offset |
| link_val | input | 32 | Link value written by a taken branch |
| add_wen | output | 16 | ADD ALU per-lane write enable |
| mul_wen | output | 16 | MUL ALU per-lane write enable |
| link_wen | output | 1 | Link register write enable |
| br_target | output | 32 | Computed branch target |
| flag_z | output | 16 | Zero flag per lane |
| flag_n | output | 16 | Negative flag per lane |
| flag_c | output | 16 | Carry flag per lane |

## Verification
Write enables, `link_wen` and `br_target` are combinational and due in the issue cycle. The bench samples them one time unit after driving the inputs on the falling edge, before the next rising edge. Flag updates pass through one register and are due in the following cycle. The bench compares them one time unit after the rising edge that ends the instruction, against a lane-by-lane model it advances at that edge. The sweep covers every pair of ADD and MUL condition codes with the nop and set-flags controls, and every combination of branch controls.

// File: rtl/flagu_pkg.sv
package flagu_pkg;

  typedef enum logic [2:0] {
    CC_NEVER  = 3'd0,
    CC_ALWAYS = 3'd1,
    CC_ZSET   = 3'd2,
    CC_ZCLR   = 3'd3,
    CC_NSET   = 3'd4,
    CC_NCLR   = 3'd5,
    CC_CSET   = 3'd6,
    CC_CCLR   = 3'd7
  } cond_e;

  typedef enum logic [1:0] {
    SRC_ADD  = 2'd0,
    SRC_MUL  = 2'd1,
    SRC_LINK = 2'd2
  } fsrc_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
  } flags_t;

  // Evaluate one condition code against one lane's flags.
  function automatic logic cond_pass(input logic [2:0] cc, input flags_t f);
    logic r;
    case (cond_e'(cc))
      CC_NEVER:  r = 1'b0;
      CC_ALWAYS: r = 1'b1;
      CC_ZSET:   r = f.z;
      CC_ZCLR:   r = ~f.z;
      CC_NSET:   r = f.n;
      CC_NCLR:   r = ~f.n;
      CC_CSET:   r = f.c;
      default:   r = ~f.c;
    endcase
    return r;
  endfunction

  // Build the flag triple from a result summary.
  function automatic flags_t flags_of(input logic all_zero, input logic msb,
                                      input logic cy);
    flags_t f;
    f.z = all_zero;
    f.n = msb;
    f.c = cy;
    return f;
  endfunction

endpackage

// File: rtl/flagu_lane_cond.sv
module flagu_lane_cond
  import flagu_pkg::*;
#(
  parameter int unsigned LANES = 16
) (
  input  logic [2:0]       cc_add,
  input  logic [2:0]       cc_mul,
  input  logic             add_live,
  input  logic             mul_live,
  input  logic [LANES-1:0] fz,
  input  logic [LANES-1:0] fn,
  input  logic [LANES-1:0] fc,
  output logic [LANES-1:0] add_wen,
  output logic [LANES-1:0] mul_wen
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    flags_t cur;
    assign cur        = flags_t'({fz[g], fn[g], fc[g]});
    assign add_wen[g] = add_live & cond_pass(cc_add, cur);
    assign mul_wen[g] = mul_live & cond_pass(cc_mul, cur);
  end

endmodule

// File: rtl/flagu_flag_next.sv
module flagu_flag_next
  import flagu_pkg::*;
#(
  parameter int unsigned LANES = 16,
  parameter int unsigned DW    = 32
) (
  input  fsrc_e                 src,
  input  logic [LANES*DW-1:0]   add_res,
  input  logic [LANES-1:0]      add_cy,
  input  logic [LANES*DW-1:0]   mul_res,
  input  logic [LANES-1:0]      mul_cy,
  input  logic [DW-1:0]         link_val,
  output logic [LANES-1:0]      nz,
  output logic [LANES-1:0]      nn,
  output logic [LANES-1:0]      nc
);

  flags_t link_f;
  assign link_f = flags_of(~|link_val, link_val[DW-1], 1'b0);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DW-1:0] a_w;
    logic [DW-1:0] m_w;
    flags_t        a_f;
    flags_t        m_f;
    flags_t        sel_f;

    assign a_w = add_res[g*DW +: DW];
    assign m_w = mul_res[g*DW +: DW];
    assign a_f = flags_of(~|a_w, a_w[DW-1], add_cy[g]);
    assign m_f = flags_of(~|m_w, m_w[DW-1], mul_cy[g]);

    always_comb begin
      case (src)
        SRC_MUL:  sel_f = m_f;
        SRC_LINK: sel_f = link_f;
        default:  sel_f = a_f;
      endcase
    end

    assign nz[g] = sel_f.z;
    assign nn[g] = sel_f.n;
    assign nc[g] = sel_f.c;
  end

endmodule

// File: rtl/flagu_branch.sv
module flagu_branch #(
  parameter int unsigned LANES = 16,
  parameter int unsigned DW    = 32
) (
  input  logic                instr_valid,
  input  logic                is_branch,
  input  logic                br_taken,
  input  logic                br_use_reg,
  input  logic [LANES*DW-1:0] br_reg_vec,
  input  logic [DW-1:0]       br_offset,
  output logic                link_wen,
  output logic [DW-1:0]       br_target
);

  localparam int unsigned SRC_LANE = LANES - 1;

  logic [DW-1:0] reg_word;
  assign reg_word  = br_use_reg ? br_reg_vec[SRC_LANE*DW +: DW] : '0;
  assign br_target = reg_word + br_offset;
  assign link_wen  = instr_valid & is_branch & br_taken;

endmodule

// File: rtl/simd_flag_unit.sv
module simd_flag_unit
  import flagu_pkg::*;
#(
  parameter int unsigned LANES = 16,
  parameter int unsigned DW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                instr_valid,
  input  logic                is_branch,
  input  logic                set_flags,
  input  logic                raddr_a_lsb,
  input  logic                add_nop,
  input  logic [2:0]          cond_add,
  input  logic [2:0]          cond_mul,
  input  logic [LANES*DW-1:0] add_res,
  input  logic [LANES-1:0]    add_cy,
  input  logic [LANES*DW-1:0] mul_res,
  input  logic [LANES-1:0]    mul_cy,
  input  logic                br_taken,
  input  logic                br_use_reg,
  input  logic [LANES*DW-1:0] br_reg_vec,
  input  logic [DW-1:0]       br_offset,
  input  logic [DW-1:0]       link_val,
  output logic [LANES-1:0]    add_wen,
  output logic [LANES-1:0]    mul_wen,
  output logic                link_wen,
  output logic [DW-1:0]       br_target,
  output logic [LANES-1:0]    flag_z,
  output logic [LANES-1:0]    flag_n,
  output logic [LANES-1:0]    flag_c
);

  // Named internal events, also used by the checker.
  logic             add_live;
  logic             mul_live;
  logic             sf_eff;
  fsrc_e            fsrc;
  logic [LANES-1:0] upd_mask;
  logic [LANES-1:0] nz, nn, nc;

  assign add_live = instr_valid & ~is_branch & ~add_nop;
  assign mul_live = instr_valid & ~is_branch;
  // On a branch the set-flags bit aliases the low register-A address bit.
  assign sf_eff   = set_flags | (is_branch & raddr_a_lsb);

  flagu_lane_cond #(.LANES(LANES)) u_cond (
    .cc_add   (cond_add),
    .cc_mul   (cond_mul),
    .add_live (add_live),
    .mul_live (mul_live),
    .fz       (flag_z),
    .fn       (flag_n),
    .fc       (flag_c),
    .add_wen  (add_wen),
    .mul_wen  (mul_wen)
  );

  always_comb begin
    if (is_branch) begin
      fsrc     = SRC_LINK;
      upd_mask = {LANES{instr_valid & sf_eff & br_taken}};
    end else if (!add_nop) begin
      fsrc     = SRC_ADD;
      upd_mask = {LANES{instr_valid & sf_eff}} & add_wen;
    end else begin
      fsrc     = SRC_MUL;
      upd_mask = {LANES{instr_valid & sf_eff}} & mul_wen;
    end
  end

  flagu_flag_next #(.LANES(LANES), .DW(DW)) u_next (
    .src      (fsrc),
    .add_res  (add_res),
    .add_cy   (add_cy),
    .mul_res  (mul_res),
    .mul_cy   (mul_cy),
    .link_val (link_val),
    .nz       (nz),
    .nn       (nn),
    .nc       (nc)
  );

  flagu_branch #(.LANES(LANES), .DW(DW)) u_br (
    .instr_valid (instr_valid),
    .is_branch   (is_branch),
    .br_taken    (br_taken),
    .br_use_reg  (br_use_reg),
    .br_reg_vec  (br_reg_vec),
    .br_offset   (br_offset),
    .link_wen    (link_wen),
    .br_target   (br_target)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_z[g] <= 1'b0;
        flag_n[g] <= 1'b0;
        flag_c[g] <= 1'b0;
      end else if (upd_mask[g]) begin
        flag_z[g] <= nz[g];
        flag_n[g] <= nn[g];
        flag_c[g] <= nc[g];
      end
    end
  end

endmodule

// File: rtl/flagu_checker.sv
module flagu_checker #(
  parameter int unsigned LANES = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             instr_valid,
  input logic             is_branch,
  input logic             br_taken,
  input logic             add_nop,
  input logic [2:0]       cond_add,
  input logic [2:0]       cond_mul,
  input logic             sf_eff,
  input logic [LANES-1:0] upd_mask,
  input logic [LANES-1:0] add_wen,
  input logic [LANES-1:0] mul_wen,
  input logic             link_wen,
  input logic [LANES-1:0] flag_z,
  input logic [LANES-1:0] flag_n,
  input logic [LANES-1:0] flag_c
);

  p_never_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_add == 3'd0) |-> (add_wen == '0));

  p_never_blocks_mul_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_mul == 3'd0) |-> (mul_wen == '0));

  p_masked_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((((flag_z ^ $past(flag_z)) | (flag_n ^ $past(flag_n)) |
                (flag_c ^ $past(flag_c))) & ~$past(upd_mask)) == '0));

  p_add_owns_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !is_branch && !add_nop) |-> ((upd_mask & ~add_wen) == '0));

  p_nop_silences_add_r5: assert property (@(posedge clk) disable iff (!rst_n)
    add_nop |-> (add_wen == '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(instr_valid && sf_eff) |=> ($stable(flag_z) && $stable(flag_n) && $stable(flag_c)));

  p_untaken_no_link_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_branch && !br_taken) |-> !link_wen);

  p_untaken_no_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && is_branch && !br_taken) |=>
      ($stable(flag_z) && $stable(flag_n) && $stable(flag_c)));

  p_branch_no_wen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_branch |-> ((add_wen | mul_wen) == '0));

  p_idle_no_wen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> ((add_wen | mul_wen) == '0 && !link_wen));

endmodule

bind simd_flag_unit flagu_checker #(.LANES(LANES)) u_flagu_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .is_branch   (is_branch),
  .br_taken    (br_taken),
  .add_nop     (add_nop),
  .cond_add    (cond_add),
  .cond_mul    (cond_mul),
  .sf_eff      (sf_eff),
  .upd_mask    (upd_mask),
  .add_wen     (add_wen),
  .mul_wen     (mul_wen),
  .link_wen    (link_wen),
  .flag_z      (flag_z),
  .flag_n      (flag_n),
  .flag_c      (flag_c)
);

// File: tb/test_simd_flag_unit.sv
module test_simd_flag_unit;

  localparam int unsigned LANES = 16;
  localparam int unsigned DW    = 32;
  localparam time         TCLK  = 10;
  localparam int unsigned WATCHDOG = 20000;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                instr_valid, is_branch, set_flags, raddr_a_lsb, add_nop;
  logic [2:0]          cond_add, cond_mul;
  logic [LANES*DW-1:0] add_res, mul_res, br_reg_vec;
  logic [LANES-1:0]    add_cy, mul_cy;
  logic                br_taken, br_use_reg;
  logic [DW-1:0]       br_offset, link_val;
  logic [LANES-1:0]    add_wen, mul_wen, flag_z, flag_n, flag_c;
  logic                link_wen;
  logic [DW-1:0]       br_target;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Bench-side flag model.
  logic [LANES-1:0] mz, mn, mc;

  always #(TCLK/2) clk = ~clk;

  simd_flag_unit #(.LANES(LANES), .DW(DW)) i_simd_flag_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .is_branch(is_branch),
    .set_flags(set_flags), .raddr_a_lsb(raddr_a_lsb), .add_nop(add_nop),
    .cond_add(cond_add), .cond_mul(cond_mul), .add_res(add_res), .add_cy(add_cy),
    .mul_res(mul_res), .mul_cy(mul_cy), .br_taken(br_taken), .br_use_reg(br_use_reg),
    .br_reg_vec(br_reg_vec), .br_offset(br_offset), .link_val(link_val),
    .add_wen(add_wen), .mul_wen(mul_wen), .link_wen(link_wen), .br_target(br_target),
    .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Condition truth written as a bit lookup: bit (2*code + flagbit).
  function automatic bit cc_ok(input logic [2:0] cc, input bit z, input bit n, input bit c);
    bit [15:0] tbl;
    bit sel;
    sel = (cc[2:1] == 2'd1) ? z : (cc[2:1] == 2'd2) ? n : c;
    tbl = 16'b0110_0110_0110_1100;  // pairs per code, index = {cc, sel}
    return tbl[{cc, sel}];
  endfunction

  function automatic logic [DW-1:0] rnd_word();
    int unsigned k = $urandom % 4;
    if (k == 0) return '0;
    if (k == 1) return 32'h8000_0000 | $urandom;
    return $urandom & 32'h7fff_ffff;
  endfunction

  task automatic load_data();
    for (int i = 0; i < LANES; i++) begin
      add_res[i*DW +: DW]    = rnd_word();
      mul_res[i*DW +: DW]    = rnd_word();
      br_reg_vec[i*DW +: DW] = $urandom;
    end
    add_cy = LANES'($urandom);
    mul_cy = LANES'($urandom);
  endtask

  // One ALU instruction: check enables in the issue cycle, flags one cycle later.
  task automatic alu_step(input logic [2:0] ca, input logic [2:0] cm,
                          input bit nop, input bit sf, input bit vld);
    logic [LANES-1:0] e_add, e_mul;
    logic [LANES-1:0] nz, nn, nc;
    @(negedge clk);
    instr_valid = vld; is_branch = 1'b0; set_flags = sf; add_nop = nop;
    raddr_a_lsb = $urandom; cond_add = ca; cond_mul = cm;
    br_taken = $urandom; link_val = $urandom;
    load_data();
    nz = mz; nn = mn; nc = mc;
    for (int i = 0; i < LANES; i++) begin
      e_add[i] = vld && !nop && cc_ok(ca, mz[i], mn[i], mc[i]);
      e_mul[i] = vld && cc_ok(cm, mz[i], mn[i], mc[i]);
      if (vld && sf) begin
        if (!nop && e_add[i]) begin
          nz[i] = (add_res[i*DW +: DW] == 0);
          nn[i] = add_res[i*DW + DW-1];
          nc[i] = add_cy[i];
        end else if (nop && e_mul[i]) begin
          nz[i] = (mul_res[i*DW +: DW] == 0);
          nn[i] = mul_res[i*DW + DW-1];
          nc[i] = mul_cy[i];
        end
      end
    end
    #1;
    check(nop ? "R5" : "R1", "add_wen", 64'(add_wen), 64'(e_add));
    check("R1", "mul_wen", 64'(mul_wen), 64'(e_mul));
    check("R1", "link_wen", 64'(link_wen), 64'd0);
    @(posedge clk);
    #1;
    mz = nz; mn = nn; mc = nc;
    check(!sf || !vld ? "R6" : (nop ? "R5" : "R4"), "flag_z", 64'(flag_z), 64'(mz));
    check("R3", "flag_n", 64'(flag_n), 64'(mn));
    check("R2", "flag_c", 64'(flag_c), 64'(mc));
  endtask

  task automatic br_step(input bit tk, input bit sf, input bit lsb, input bit ur,
                         input logic [DW-1:0] lv);
    logic [DW-1:0] exp_t;
    bit upd;
    @(negedge clk);
    instr_valid = 1'b1; is_branch = 1'b1; set_flags = sf; raddr_a_lsb = lsb;
    add_nop = $urandom; cond_add = 3'd1; cond_mul = 3'd1;
    br_taken = tk; br_use_reg = ur; link_val = lv; br_offset = $urandom;
    load_data();
    exp_t = (ur ? br_reg_vec[(LANES-1)*DW +: DW] : '0) + br_offset;
    #1;
    check("R9", "add_wen|mul_wen", 64'(add_wen | mul_wen), 64'd0);
    check("R8", "link_wen", 64'(link_wen), 64'(tk));
    check("R10", "br_target", 64'(br_target), 64'(exp_t));
    upd = tk && (sf || lsb);
    @(posedge clk);
    #1;
    if (upd) begin
      mz = {LANES{lv == 0}};
      mn = {LANES{lv[DW-1]}};
      mc = '0;
    end
    check(lsb && !sf ? "R7" : "R8", "flag_z", 64'(flag_z), 64'(mz));
    check("R8", "flag_n", 64'(flag_n), 64'(mn));
    check("R8", "flag_c", 64'(flag_c), 64'(mc));
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0; instr_valid = 1'b0; is_branch = 1'b0; set_flags = 1'b0;
    raddr_a_lsb = 1'b0; add_nop = 1'b0; cond_add = '0; cond_mul = '0;
    add_res = '0; mul_res = '0; br_reg_vec = '0; add_cy = '0; mul_cy = '0;
    br_taken = 1'b0; br_use_reg = 1'b0; br_offset = '0; link_val = '0;
    mz = '0; mn = '0; mc = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R11", "flag_z reset", 64'(flag_z), 64'd0);
    check("R11", "flag_n reset", 64'(flag_n), 64'd0);
    check("R11", "flag_c reset", 64'(flag_c), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Seed varied flags, then sweep every condition pair with nop and sf.
    for (int r = 0; r < 2; r++) begin
      for (int ca = 0; ca < 8; ca++)
        for (int cm = 0; cm < 8; cm++)
          for (int nop = 0; nop < 2; nop++)
            for (int sf = 0; sf < 2; sf++)
              alu_step(3'(ca), 3'(cm), bit'(nop), bit'(sf), 1'b1);
    end
    // Idle cycles with update requests present must change nothing (R6).
    for (int k = 0; k < 8; k++) alu_step(3'd1, 3'd1, bit'(k & 1), 1'b1, 1'b0);

    // Branch sweep: taken, explicit sf, aliased address bit, register use (R7, R8, R10).
    for (int k = 0; k < 16; k++) begin
      alu_step(3'd1, 3'd1, 1'b0, 1'b1, 1'b1);  // scramble flags first
      br_step(bit'(k[0]), bit'(k[1]), bit'(k[2]), bit'(k[3]),
              (k % 3 == 0) ? 32'h0 : (k % 3 == 1) ? 32'h8000_1000 : 32'h0000_0400);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule